// File: doc/BRIEF.md
# Two-Share Masked AND with Three-Share Core

This block computes the bitwise AND of two secret operands while neither operand ever appears unmasked in the datapath. Each operand reaches it as two Boolean shares whose XOR is the real value. The datapath around it stays in two shares. Only this gate widens to three shares. For each bit it takes one fresh random bit per operand and adds a third share, so the XOR of the three shares is unchanged.

The nonlinear product is split into three component functions. Each one sees only two of the three share indices of each operand. These components are captured in a register bank, so glitches cannot bring all shares together in one combinational cone. One fresh refresh bit per result bit goes into both output shares as the three components are folded back to two. The folded result is registered again, so the result shares leave the block two clock cycles after the operands enter. A valid flag travels alongside the data, and a new operation can start on every cycle.

Top module: `masked_and2`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation completes, `valid_out` is 0 and both result shares are all zeros.
- R2: An operation presented with `valid_in` high at a rising clock edge raises `valid_out` after the second rising edge that follows. `valid_out` is low after the first of those edges, unless an earlier operation is completing.
- R3: For every result bit i, `q_s0[i] ^ q_s1[i]` equals `(a_s0[i]^a_s1[i]) & (b_s0[i]^b_s1[i])` for any choice of shares and random bits.
- R4: The result is correct at the operand extremes: all-zero and all-one unmasked operands, each under zero masks and under random masks.
- R5: Random bit use: `rnd_reshare[i]` (ra) masks operand a bit i, `rnd_reshare[WIDTH+i]` (rb) masks operand b bit i, and `rnd_refresh[i]` (m) refreshes result bit i. Result share 0 is exactly `q_s0[i] = a_s1&b_s1 ^ a_s1&rb ^ ra&b_s1 ^ m`, with all terms taken at bit i.
- R6: A cycle with `valid_in` low leaves both result shares unchanged and drives `valid_out` low on the next edge, whatever values the other inputs carry.
- R7: Operations presented on consecutive cycles each produce their own correct result on consecutive cycles, two cycles later.
- R8: Non-completeness: result share 0 does not depend on `a_s0` or `b_s0`. Changing only those inputs leaves `q_s0` unchanged.
- R9: Refresh: flipping refresh bits while every other input stays the same flips exactly those bits in both result shares and leaves their XOR unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and random bits are valid this cycle |
| a_s0 | input | WIDTH | Operand a, share 0 |
| a_s1 | input | WIDTH | Operand a, share 1 |
| b_s0 | input | WIDTH | Operand b, share 0 |
| b_s1 | input | WIDTH | Operand b, share 1 |
| rnd_reshare | input | 2*WIDTH | Fresh bits for share expansion (low half for a, high half for b) |
| rnd_refresh | input | WIDTH | Fresh bits for the output refresh |
| valid_out | output | 1 | Result shares hold a new result |
| q_s0 | output | WIDTH | Result share 0 |
| q_s1 | output | WIDTH | Result share 1 |

## Verification
The hardest properties to observe from the ports are non-completeness and the refresh. An unmasked result check passes even when a component function reaches for a forbidden share or the refresh bit is dropped. The bench therefore runs pairs of operations that differ in only one group of inputs. The first kind of pair changes just share 0 of both operands, which changes the true result but must leave result share 0 untouched. The second kind of pair changes only the refresh bits, which must flip both result shares bit for bit. Individual share values are also compared against the closed-form share-0 expression, so swapping any random bit to a different role shows up.

// File: rtl/masked_and_pkg.sv
package masked_and_pkg;

   // One non-complete component of the three-share AND.
   // (p,q) are two shares of x, (u,v) the same two share indices of y.
   // The result involves only these two indices, never the third.
   function automatic logic nc_term(input logic p, input logic q,
                                    input logic u, input logic v);
      return (p & u) ^ (p & v) ^ (q & u);
   endfunction

   // Number of clock cycles from operand capture to result, per variant
   function automatic int unsigned pipe_depth(input bit out_reg);
      return out_reg ? 2 : 1;
   endfunction

endpackage

// File: rtl/share_expand.sv
module share_expand #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_s0,
   input  logic [WIDTH-1:0] a_s1,
   input  logic [WIDTH-1:0] b_s0,
   input  logic [WIDTH-1:0] b_s1,
   input  logic [WIDTH-1:0] rnd_a,
   input  logic [WIDTH-1:0] rnd_b,
   output logic [WIDTH-1:0] x0,
   output logic [WIDTH-1:0] x1,
   output logic [WIDTH-1:0] x2,
   output logic [WIDTH-1:0] y0,
   output logic [WIDTH-1:0] y1,
   output logic [WIDTH-1:0] y2
);

   if (WIDTH < 1) begin : g_bad_width
      $error("share_expand: WIDTH must be at least 1");
   end

   // Third share is the random bit itself; it is cancelled in share 0,
   // so the XOR of the three shares equals the two-share XOR.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         x0[i] = a_s0[i] ^ rnd_a[i];
         x1[i] = a_s1[i];
         x2[i] = rnd_a[i];
         y0[i] = b_s0[i] ^ rnd_b[i];
         y1[i] = b_s1[i];
         y2[i] = rnd_b[i];
      end
   end

endmodule

// File: rtl/ti_and_core.sv
module ti_and_core
   import masked_and_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WIDTH-1:0] x0,
   input  logic [WIDTH-1:0] x1,
   input  logic [WIDTH-1:0] x2,
   input  logic [WIDTH-1:0] y0,
   input  logic [WIDTH-1:0] y1,
   input  logic [WIDTH-1:0] y2,
   input  logic [WIDTH-1:0] refresh_in,
   output logic [WIDTH-1:0] z0_q,
   output logic [WIDTH-1:0] z1_q,
   output logic [WIDTH-1:0] z2_q,
   output logic [WIDTH-1:0] m_q,
   output logic             v_q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ti_and_core: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] z0_d, z1_d, z2_d;

   // Component k leaves out share index k of both operands
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         z0_d[i] = nc_term(x1[i], x2[i], y1[i], y2[i]);
         z1_d[i] = nc_term(x2[i], x0[i], y2[i], y0[i]);
         z2_d[i] = nc_term(x0[i], x1[i], y0[i], y1[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z0_q <= '0;
         z1_q <= '0;
         z2_q <= '0;
         m_q  <= '0;
         v_q  <= 1'b0;
      end else begin
         v_q <= en;
         if (en) begin
            z0_q <= z0_d;
            z1_q <= z1_d;
            z2_q <= z2_d;
            m_q  <= refresh_in;
         end
      end
   end

   // R3
   core_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((z0_q ^ z1_q ^ z2_q) == $past((x0 ^ x1 ^ x2) & (y0 ^ y1 ^ y2))));

   // R6
   core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(z0_q) && $stable(z1_q) && $stable(z2_q) && $stable(m_q) && !v_q));

   // R2
   core_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> v_q);

endmodule

// File: rtl/share_compress.sv
module share_compress #(
   parameter int unsigned WIDTH   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_in,
   input  logic [WIDTH-1:0] z0,
   input  logic [WIDTH-1:0] z1,
   input  logic [WIDTH-1:0] z2,
   input  logic [WIDTH-1:0] m,
   output logic [WIDTH-1:0] q0,
   output logic [WIDTH-1:0] q1,
   output logic             v_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("share_compress: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] c0, c1;

   // Refresh bit enters both shares; the two shares then carry
   // z0 and z1^z2 respectively, so their XOR is the full product.
   always_comb begin
      c0 = z0 ^ m;
      c1 = z1 ^ z2 ^ m;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q0    <= '0;
            q1    <= '0;
            v_out <= 1'b0;
         end else begin
            v_out <= v_in;
            if (v_in) begin
               q0 <= c0;
               q1 <= c1;
            end
         end
      end

      // R3
      cmp_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
         v_in |=> ((q0 ^ q1) == $past(z0 ^ z1 ^ z2)));

      // R6
      cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !v_in |=> ($stable(q0) && $stable(q1) && !v_out));

      // R2
      cmp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         v_in |=> v_out);
   end else begin : g_comb
      always_comb begin
         q0    = c0;
         q1    = c1;
         v_out = v_in;
      end
   end

endmodule

// File: rtl/masked_and2.sv
module masked_and2
   import masked_and_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_in,
   input  logic [WIDTH-1:0]   a_s0,
   input  logic [WIDTH-1:0]   a_s1,
   input  logic [WIDTH-1:0]   b_s0,
   input  logic [WIDTH-1:0]   b_s1,
   input  logic [2*WIDTH-1:0] rnd_reshare,
   input  logic [WIDTH-1:0]   rnd_refresh,
   output logic               valid_out,
   output logic [WIDTH-1:0]   q_s0,
   output logic [WIDTH-1:0]   q_s1
);

   localparam int unsigned LATENCY = pipe_depth(OUT_REG);
   localparam int unsigned RND_W   = 2 * WIDTH;

   if (WIDTH < 1) begin : g_bad_width
      $error("masked_and2: WIDTH must be at least 1");
   end
   if (LATENCY < 1 || LATENCY > 2) begin : g_bad_lat
      $error("masked_and2: unsupported pipeline depth");
   end

   logic [WIDTH-1:0] x0, x1, x2, y0, y1, y2;
   logic [WIDTH-1:0] z0, z1, z2, m;
   logic             v1;

   share_expand #(.WIDTH(WIDTH)) u_expand (
      .a_s0  (a_s0),
      .a_s1  (a_s1),
      .b_s0  (b_s0),
      .b_s1  (b_s1),
      .rnd_a (rnd_reshare[WIDTH-1:0]),
      .rnd_b (rnd_reshare[RND_W-1:WIDTH]),
      .x0    (x0),
      .x1    (x1),
      .x2    (x2),
      .y0    (y0),
      .y1    (y1),
      .y2    (y2)
   );

   ti_and_core #(.WIDTH(WIDTH)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (valid_in),
      .x0         (x0),
      .x1         (x1),
      .x2         (x2),
      .y0         (y0),
      .y1         (y1),
      .y2         (y2),
      .refresh_in (rnd_refresh),
      .z0_q       (z0),
      .z1_q       (z1),
      .z2_q       (z2),
      .m_q        (m),
      .v_q        (v1)
   );

   share_compress #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_compress (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (v1),
      .z0    (z0),
      .z1    (z1),
      .z2    (z2),
      .m     (m),
      .q0    (q_s0),
      .q1    (q_s1),
      .v_out (valid_out)
   );

   if (LATENCY == 2) begin : g_top_chk
      // R3 end-to-end, from port operands to port result
      e2e_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
         valid_out |-> ((q_s0 ^ q_s1) ==
                        $past((a_s0 ^ a_s1) & (b_s0 ^ b_s1), 2)));
   end

endmodule

// File: tb/masked_and2_test.sv
module masked_and2_test;

   localparam int unsigned W      = 32;
   localparam time         CLK_PER = 10ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           valid_in = 1'b0;
   logic [W-1:0]   a_s0 = '0, a_s1 = '0, b_s0 = '0, b_s1 = '0;
   logic [2*W-1:0] rnd_reshare = '0;
   logic [W-1:0]   rnd_refresh = '0;
   logic           valid_out;
   logic [W-1:0]   q_s0, q_s1;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   masked_and2 #(.WIDTH(W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_in    (valid_in),
      .a_s0        (a_s0),
      .a_s1        (a_s1),
      .b_s0        (b_s0),
      .b_s1        (b_s1),
      .rnd_reshare (rnd_reshare),
      .rnd_refresh (rnd_refresh),
      .valid_out   (valid_out),
      .q_s0        (q_s0),
      .q_s1        (q_s1)
   );

   typedef struct {
      logic [W-1:0] a0, a1, b0, b1, ra, rb, m;
   } op_t;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic op_t rand_op();
      op_t o;
      o.a0 = $urandom; o.a1 = $urandom; o.b0 = $urandom; o.b1 = $urandom;
      o.ra = $urandom; o.rb = $urandom; o.m  = $urandom;
      return o;
   endfunction

   // Share-0 formula from R5
   function automatic logic [W-1:0] exp_s0(input op_t o);
      return (o.a1 & o.b1) ^ (o.a1 & o.rb) ^ (o.ra & o.b1) ^ o.m;
   endfunction

   function automatic logic [W-1:0] exp_prod(input op_t o);
      return (o.a0 ^ o.a1) & (o.b0 ^ o.b1);
   endfunction

   task automatic drive(input op_t o, input logic v);
      valid_in    = v;
      a_s0        = o.a0;
      a_s1        = o.a1;
      b_s0        = o.b0;
      b_s1        = o.b1;
      rnd_reshare = {o.rb, o.ra};
      rnd_refresh = o.m;
   endtask

   task automatic check_result(input op_t o, input string tag);
      check({tag, " R2 valid_out"}, W'(valid_out), W'(1));
      check({tag, " R3 share xor"}, q_s0 ^ q_s1, exp_prod(o));
      check({tag, " R5 share0"}, q_s0, exp_s0(o));
   endtask

   // Single isolated operation; returns after the result is sampled
   task automatic run_one(input op_t o, input string tag);
      @(negedge clk);
      drive(o, 1'b1);
      @(negedge clk);
      drive(rand_op(), 1'b0);
      check({tag, " R2 early"}, W'(valid_out), W'(0));
      @(negedge clk);
      check_result(o, tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", W'(valid_out), W'(0));
      check("R1 q_s0 in reset", q_s0, '0);
      check("R1 q_s1 in reset", q_s1, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 valid after release", W'(valid_out), W'(0));
      check("R1 q_s0 after release", q_s0, '0);
   endtask

   task automatic t_random();
      for (int k = 0; k < 20; k++) run_one(rand_op(), "random");
   endtask

   task automatic t_corners();
      op_t o;
      for (int k = 0; k < 4; k++) begin
         o = (k % 2 == 0) ? '{'0, '0, '0, '0, '0, '0, '0} : rand_op();
         // k<2: all-zero unmasked, else all-ones unmasked
         o.a1 = o.a0 ^ ((k < 2) ? '0 : '1);
         o.b1 = o.b0 ^ ((k < 2) ? '0 : '1);
         run_one(o, "R4 corner");
         check("R4 corner product", q_s0 ^ q_s1, (k < 2) ? '0 : '1);
      end
      o = rand_op();
      o.a1 = o.a0 ^ '1;
      o.b1 = o.b0;
      run_one(o, "R4 ones-and-zeros");
      check("R4 ones-and-zeros product", q_s0 ^ q_s1, '0);
   endtask

   task automatic t_hold();
      logic [W-1:0] h0, h1;
      run_one(rand_op(), "hold-setup");
      h0 = q_s0;
      h1 = q_s1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         drive(rand_op(), 1'b0);
         check("R6 valid_out idle", W'(valid_out), W'(0));
         check("R6 q_s0 held", q_s0, h0);
         check("R6 q_s1 held", q_s1, h1);
      end
   endtask

   task automatic t_stream();
      op_t ops[8];
      for (int k = 0; k < 8; k++) ops[k] = rand_op();
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            check("R7 stream valid", W'(valid_out), W'(1));
            check("R7 stream xor", q_s0 ^ q_s1, exp_prod(ops[k-2]));
            check("R7 stream share0", q_s0, exp_s0(ops[k-2]));
         end
         if (k < 8) drive(ops[k], 1'b1);
         else       drive(rand_op(), 1'b0);
      end
      @(negedge clk);
      check("R7 stream ends", W'(valid_out), W'(0));
   endtask

   task automatic t_noncomplete();
      op_t o1, o2;
      logic [W-1:0] r1;
      for (int k = 0; k < 4; k++) begin
         o1 = rand_op();
         o2 = o1;
         o2.a0 = $urandom;
         o2.b0 = $urandom;
         run_one(o1, "R8 first");
         r1 = q_s0;
         run_one(o2, "R8 second");
         check("R8 share0 independent of share-0 inputs", q_s0, r1);
      end
   endtask

   task automatic t_refresh();
      op_t o1, o2;
      logic [W-1:0] p0, p1, flip;
      for (int k = 0; k < 4; k++) begin
         o1 = rand_op();
         o2 = o1;
         flip = (k == 0) ? '1 : W'($urandom);
         o2.m = o1.m ^ flip;
         run_one(o1, "R9 first");
         p0 = q_s0;
         p1 = q_s1;
         run_one(o2, "R9 second");
         check("R9 share0 flips", q_s0 ^ p0, flip);
         check("R9 share1 flips", q_s1 ^ p1, flip);
         check("R9 xor unchanged", q_s0 ^ q_s1, p0 ^ p1);
      end
   endtask

   initial begin
      t_reset();
      t_random();
      t_corners();
      t_hold();
      t_stream();
      t_noncomplete();
      t_refresh();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule